// File: doc/BRIEF.md
# Cascadable Interval Timer Group

This block holds four 32-bit down-counting interval timers behind a single-cycle register port. A shared prescaler divides the core clock into count ticks. Every timer that is not inhibited decrements once per tick. When it reaches the end of its interval it reloads its base value, flips a toggle bit and raises its own active-low level interrupt. The interrupt stays asserted until software reads the timer's current count or writes its base count.

Neighbouring timers can be joined into one longer counter. In a joined pair the lower-numbered timer is a full 32-bit low part, and the higher-numbered timer is the upper part. The upper part counts once for each full pass of the low part, and only the upper timer signals the end of the combined interval. Per-pair rollover control decides whether the joined counter restarts or comes to rest at zero. Each timer also has two words of plain storage for software's routing information.

Top module: `tmr_group`

## Requirements
- R1: After reset every interrupt output is high, every base-count word reads 0x80000000 (inhibited, value zero), every other register reads zero and the prescaler divides by 8.
- R2: Group control bits 9:8 select the tick period: 0 gives one tick every 8 clocks, 1 every 16, 2 every 32 and 3 every 64. The first tick comes on the eighth clock edge after the internal reset releases.
- R3: An enabled timer that is not part of a pair works on count bits 30:0. On a tick with a count of 2 or more it decrements. On a tick with a count of 0 or 1 it loads base bits 30:0, inverts its toggle bit (bit 31 of the current-count word) and raises its interrupt.
- R4: Setting bit 31 of the base-count word stops the timer; its count holds across ticks.
- R5: A base-count write loads the written value into the current count when the timer was inhibited before the write or the written word has bit 31 set. For the low timer of a pair, the upper timer's inhibit bit decides this.
- R6: Interrupt outputs are active-low levels. A timer's output clears on a read of that timer's current count or a write of its base count, unless an expiry sets it again in the same cycle.
- R7: A write to the current-count word replaces the count (bits 30:0, or all 32 bits for a pair's low timer). This takes precedence over counting in that cycle.
- R8: Control bit k (k = 0..2) joins timer k (low, all 32 bits) with timer k+1 (high, bits 30:0). The pair value is high*0xFFFFFFFF+low and drops by one per tick. With a low count of 0 and a nonzero high count, the high count drops by one and the low count becomes 0xFFFFFFFE. The high timer's inhibit bit gates the pair. The low timer's interrupt never fires.
- R9: Control bit 24+k is pair k's rollover bit. When the pair value is 0 or 1 on a tick and the bit is set, both halves reload, the high timer's toggle bit flips and its interrupt fires. When the bit is clear, a value of 1 goes to 0 and fires once, and a value of 0 then stays at 0 without firing.
- R10: When two overlapping join bits are set, the lower-numbered pair wins. Pair 1 is active only if pair 0 is not, and pair 2 is active only if pair 1 is not active.
- R11: The routing and destination words of each timer read back the last value written and have no effect on counting.
- R12: Byte addresses: timer n occupies 0x40*n, with current count at +0x00, base count at +0x10, routing at +0x20 and destination at +0x30. The group control word is at 0x100. Address bits 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe (triggers interrupt clear) |
| addr | input | 9 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_n | output | 4 | Per-timer active-low interrupt levels |

## Verification
The bench goes after the borrow step of a joined pair. A design that wraps the low half to all-ones instead of 0xFFFFFFFE, or that lets the high half hold, shows up in read-back counts and in shifted interrupt timing. It checks that the low timer of a pair stays silent, and that a pair with rollover clear comes to rest instead of firing on every tick. It checks that overlapping join bits resolve to the lower pair, and that base writes copy into the count only when the timer is or becomes inhibited. A wrong choice in any of these moves an interrupt edge or a read value against the cycle-accurate model.

// File: rtl/tmr_group_pkg.sv
package tmr_group_pkg;

  // control word field positions (software-visible layout)
  localparam int SEL_LSB = 8;
  localparam int ROV_LSB = 24;

  // register offsets inside one timer block
  localparam int RSEL_LSB = 4;
  localparam int TMR_LSB  = 6;

  typedef enum logic [1:0] {
    RS_CUR  = 2'd0,
    RS_BASE = 2'd1,
    RS_VEC  = 2'd2,
    RS_DST  = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_DEC,
    OP_RELOAD,
    OP_BORROW,
    OP_CLEAR
  } tmr_op_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_LOG2_MIN = 3,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PS_W = DIV_LOG2_MIN + (1 << SEL_W);

  logic [PS_W-1:0] pre_q, pre_d, limit;

  always_comb begin
    limit = (PS_W'(1) << (DIV_LOG2_MIN + int'(sel))) - PS_W'(1);
    tick  = (pre_q >= limit);
    pre_d = tick ? '0 : pre_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
  import tmr_group_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int DATA_W  = 32
) (
  input  logic                            tick,
  input  logic [NUM_TMR-2:0]              casc,
  input  logic [NUM_TMR-2:0]              rov,
  input  logic [NUM_TMR-1:0]              inh_bit,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  cnt,
  output logic [NUM_TMR-1:0]              wide,
  output logic [NUM_TMR-1:0]              inh_eff,
  output logic [NUM_TMR-1:0]              expire,
  output tmr_op_e                         op [NUM_TMR]
);
  logic [NUM_TMR-2:0] pair_on;
  logic [NUM_TMR-1:0] upper;
  logic               prev;
  logic               unused_msb;

  assign unused_msb = cnt[NUM_TMR-1][DATA_W-1];

  always_comb begin
    prev  = 1'b0;
    wide  = '0;
    upper = '0;
    for (int k = 0; k < NUM_TMR-1; k++) begin
      pair_on[k]  = casc[k] & ~prev;
      prev        = pair_on[k];
      wide[k]     = pair_on[k];
      upper[k+1]  = pair_on[k];
    end

    inh_eff = inh_bit;
    for (int k = 0; k < NUM_TMR-1; k++)
      if (pair_on[k]) inh_eff[k] = inh_bit[k+1];

    expire = '0;
    for (int i = 0; i < NUM_TMR; i++) op[i] = OP_HOLD;

    // lone timers
    for (int i = 0; i < NUM_TMR; i++) begin
      if (!wide[i] && !upper[i] && tick && !inh_bit[i]) begin
        if (cnt[i][DATA_W-2:0] <= (DATA_W-1)'(1)) begin
          op[i]     = OP_RELOAD;
          expire[i] = 1'b1;
        end else begin
          op[i] = OP_DEC;
        end
      end
    end

    // joined pairs: k low, k+1 high
    for (int k = 0; k < NUM_TMR-1; k++) begin
      if (pair_on[k] && tick && !inh_bit[k+1]) begin
        if (cnt[k+1][DATA_W-2:0] == '0 && cnt[k] <= DATA_W'(1)) begin
          if (rov[k]) begin
            op[k]       = OP_RELOAD;
            op[k+1]     = OP_RELOAD;
            expire[k+1] = 1'b1;
          end else if (cnt[k] == DATA_W'(1)) begin
            op[k]       = OP_CLEAR;
            op[k+1]     = OP_CLEAR;
            expire[k+1] = 1'b1;
          end
        end else if (cnt[k] == '0) begin
          op[k]   = OP_BORROW;
          op[k+1] = OP_DEC;
        end else begin
          op[k] = OP_DEC;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_group_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  tmr_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] base_val,
  input  logic              expire,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] cnt_q,
  output logic              tog_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] cnt_d, lo_mask;
  logic              cnt_en, tog_d, irq_d;

  assign lo_mask = wide ? '1 : {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      OP_DEC:    cnt_d = (cnt_q & lo_mask) - DATA_W'(1);
      OP_RELOAD: cnt_d = base_val & lo_mask;
      OP_BORROW: cnt_d = {{(DATA_W-1){1'b1}}, 1'b0};
      OP_CLEAR:  cnt_d = '0;
      default:   cnt_d = cnt_q;
    endcase
    if (ld_en) cnt_d = ld_data & lo_mask;
    cnt_en = ld_en | (op != OP_HOLD);
    tog_d  = tog_q ^ expire;
    irq_d  = expire ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      tog_q <= tog_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_group_pkg::*;
#(
  parameter int NUM_TMR      = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 9,
  parameter int DIV_LOG2_MIN = 3,
  parameter int SEL_W        = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_TMR-1:0] irq_n
);
  localparam int TSEL_W   = $clog2(NUM_TMR);
  localparam int CTRL_BIT = TMR_LSB + TSEL_W;
  localparam int NPAIR    = NUM_TMR - 1;

  logic sync1_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      srst_n  <= sync1_q;
    end
  end

  // decode
  logic              is_ctrl;
  logic [TSEL_W-1:0] tsel;
  reg_sel_e          rsel;
  logic              unused_addr;
  assign is_ctrl     = addr[CTRL_BIT];
  assign tsel        = addr[TMR_LSB +: TSEL_W];
  assign rsel        = reg_sel_e'(addr[RSEL_LSB +: 2]);
  assign unused_addr = ^addr[RSEL_LSB-1:0];

  // group control
  logic [SEL_W-1:0] sel_q;
  logic [NPAIR-1:0] casc_q, rov_q;
  logic             ctrl_we;
  assign ctrl_we = wr_en & is_ctrl;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_q  <= '0;
      casc_q <= '0;
      rov_q  <= '0;
    end else if (ctrl_we) begin
      sel_q  <= wdata[SEL_LSB +: SEL_W];
      casc_q <= wdata[0 +: NPAIR];
      rov_q  <= wdata[ROV_LSB +: NPAIR];
    end
  end

  logic tick;
  tmr_prescaler #(.DIV_LOG2_MIN(DIV_LOG2_MIN), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .srst_n(srst_n), .sel(sel_q), .tick(tick)
  );

  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_q, base_q, vec_q, dst_q;
  logic [NUM_TMR-1:0] inh_bit, wide, inh_eff, expire, tog_q, irq_q;
  logic [NUM_TMR-1:0] up_inh, wr_base, ld_en, irq_clr;
  tmr_op_e            op [NUM_TMR];

  tmr_seq #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W)) u_seq (
    .tick(tick), .casc(casc_q), .rov(rov_q), .inh_bit(inh_bit), .cnt(cnt_q),
    .wide(wide), .inh_eff(inh_eff), .expire(expire), .op(op)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic hit, wr_cur, wr_vec, wr_dst, rd_cur, base_copy;
    assign hit     = ~is_ctrl & (tsel == TSEL_W'(i));
    assign wr_cur  = wr_en & hit & (rsel == RS_CUR);
    assign wr_base[i] = wr_en & hit & (rsel == RS_BASE);
    assign wr_vec  = wr_en & hit & (rsel == RS_VEC);
    assign wr_dst  = wr_en & hit & (rsel == RS_DST);
    assign rd_cur  = rd_en & hit & (rsel == RS_CUR);
    assign inh_bit[i] = base_q[i][DATA_W-1];

    if (i < NUM_TMR-1) begin : g_up
      assign up_inh[i] = base_q[i+1][DATA_W-1];
    end else begin : g_top
      assign up_inh[i] = 1'b0;
    end

    assign base_copy  = wr_base[i] &
                        (wide[i] ? up_inh[i] : (base_q[i][DATA_W-1] | wdata[DATA_W-1]));
    assign ld_en[i]   = wr_cur | base_copy;
    assign irq_clr[i] = rd_cur | wr_base[i];

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        base_q[i] <= {1'b1, {(DATA_W-1){1'b0}}};
        vec_q[i]  <= '0;
        dst_q[i]  <= '0;
      end else begin
        if (wr_base[i]) base_q[i] <= wdata;
        if (wr_vec)     vec_q[i]  <= wdata;
        if (wr_dst)     dst_q[i]  <= wdata;
      end
    end

    tmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .srst_n(srst_n), .op(op[i]), .wide(wide[i]),
      .base_val(base_q[i]), .expire(expire[i]), .ld_en(ld_en[i]),
      .ld_data(wdata), .irq_clr(irq_clr[i]),
      .cnt_q(cnt_q[i]), .tog_q(tog_q[i]), .irq_q(irq_q[i])
    );
  end

  assign irq_n = ~irq_q;

  always_comb begin
    rdata = '0;
    if (is_ctrl) begin
      rdata[0 +: NPAIR]       = casc_q;
      rdata[SEL_LSB +: SEL_W] = sel_q;
      rdata[ROV_LSB +: NPAIR] = rov_q;
    end else begin
      unique case (rsel)
        RS_CUR:  rdata = wide[tsel] ? cnt_q[tsel] : {tog_q[tsel], cnt_q[tsel][DATA_W-2:0]};
        RS_BASE: rdata = base_q[tsel];
        RS_VEC:  rdata = vec_q[tsel];
        default: rdata = dst_q[tsel];
      endcase
    end
  end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk #(
  parameter int NUM_TMR = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 9
) (
  input logic                           clk,
  input logic                           srst_n,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [ADDR_W-1:0]              addr,
  input logic                           tick,
  input logic [NUM_TMR-1:0]             wide,
  input logic [NUM_TMR-1:0]             inh_eff,
  input logic [NUM_TMR-1:0]             expire,
  input logic [NUM_TMR-1:0][DATA_W-1:0] cnt_q,
  input logic [NUM_TMR-1:0]             irq_n
);
  localparam int TSEL_W = $clog2(NUM_TMR);
  logic unused_lo;
  assign unused_lo = ^addr[3:0];

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!srst_n)
    tick |=> !tick);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    logic rd_cur_i;
    assign rd_cur_i = rd_en && !addr[6+TSEL_W] && (addr[6 +: TSEL_W] == TSEL_W'(i))
                      && (addr[5:4] == 2'd0);

    // R4
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (inh_eff[i] && !wr_en) |=> $stable(cnt_q[i]));

    // R6
    irq_from_expiry_chk: assert property (@(posedge clk) disable iff (!srst_n)
      $fell(irq_n[i]) |-> $past(expire[i]));

    // R6
    irq_read_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (rd_cur_i && !expire[i]) |=> irq_n[i]);

    // R8
    low_half_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
      wide[i] |-> !expire[i]);
  end
endmodule

bind tmr_group tmr_group_chk #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tick(tick), .wide(wide), .inh_eff(inh_eff), .expire(expire),
  .cnt_q(cnt_q), .irq_n(irq_n)
);

// File: tb/tmr_group_tb.sv
module tmr_group_tb;
  localparam bit [31:0] MASK = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_n;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  tmr_group u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_cnt[4], m_base[4], m_vec[4], m_dst[4];
  bit        m_tog[4], m_irq[4];
  int        m_sel, m_pre, m_rsync;
  bit [2:0]  m_casc, m_rov;

  function automatic void m_reset();
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_base[i] = 32'h8000_0000; m_vec[i] = 0; m_dst[i] = 0;
      m_tog[i] = 0; m_irq[i] = 0;
    end
    m_sel = 0; m_pre = 0; m_casc = 0; m_rov = 0;
  endfunction

  function automatic void m_pairs(output bit po[3], output bit wd[4], output bit up[4]);
    po[0] = m_casc[0];
    po[1] = m_casc[1] && !po[0];
    po[2] = m_casc[2] && !po[1];
    for (int i = 0; i < 4; i++) begin wd[i] = 0; up[i] = 0; end
    for (int k = 0; k < 3; k++) if (po[k]) begin wd[k] = 1; up[k+1] = 1; end
  endfunction

  function automatic bit [31:0] m_read(input bit [8:0] a);
    bit po[3]; bit wd[4]; bit up[4];
    int t; bit [31:0] v;
    m_pairs(po, wd, up);
    v = 0;
    if (a[8]) begin
      v[2:0] = m_casc; v[9:8] = m_sel[1:0]; v[26:24] = m_rov;
      return v;
    end
    t = int'(a[7:6]);
    case (a[5:4])
      2'd0: v = wd[t] ? m_cnt[t] : {m_tog[t], m_cnt[t][30:0]};
      2'd1: v = m_base[t];
      2'd2: v = m_vec[t];
      default: v = m_dst[t];
    endcase
    return v;
  endfunction

  function automatic void m_step();
    bit po[3]; bit wd[4]; bit up[4]; bit ex[4]; bit tick;
    bit [31:0] nc[4], hi, lo;
    int t; bit cp;
    m_pairs(po, wd, up);
    tick  = (m_pre >= (8 << m_sel) - 1);
    m_pre = tick ? 0 : m_pre + 1;
    for (int i = 0; i < 4; i++) begin nc[i] = m_cnt[i]; ex[i] = 0; end
    for (int i = 0; i < 4; i++)
      if (!wd[i] && !up[i] && tick && !m_base[i][31]) begin
        if ((m_cnt[i] & MASK) <= 1) begin nc[i] = m_base[i] & MASK; ex[i] = 1; end
        else nc[i] = (m_cnt[i] & MASK) - 1;
      end
    for (int k = 0; k < 3; k++)
      if (po[k] && tick && !m_base[k+1][31]) begin
        hi = m_cnt[k+1] & MASK; lo = m_cnt[k];
        if (hi == 0 && lo <= 1) begin
          if (m_rov[k]) begin
            nc[k] = m_base[k]; nc[k+1] = m_base[k+1] & MASK; ex[k+1] = 1;
          end else if (lo == 1) begin
            nc[k] = 0; nc[k+1] = 0; ex[k+1] = 1;
          end
        end else if (lo == 0) begin
          nc[k] = 32'hFFFF_FFFE; nc[k+1] = hi - 1;
        end else nc[k] = lo - 1;
      end
    for (int i = 0; i < 4; i++) m_tog[i] ^= ex[i];
    t = int'(addr[7:6]);
    if (wr_en) begin
      if (addr[8]) begin
        m_casc = wdata[2:0]; m_sel = int'(wdata[9:8]); m_rov = wdata[26:24];
      end else case (addr[5:4])
        2'd0: nc[t] = wd[t] ? wdata : (wdata & MASK);
        2'd1: begin
          if (wd[t]) cp = (t < 3) ? m_base[t+1][31] : 1'b0;
          else       cp = m_base[t][31] | wdata[31];
          if (cp) nc[t] = wd[t] ? wdata : (wdata & MASK);
          m_base[t] = wdata;
        end
        2'd2: m_vec[t] = wdata;
        default: m_dst[t] = wdata;
      endcase
    end
    for (int i = 0; i < 4; i++) begin
      if (ex[i]) m_irq[i] = 1;
      else if (!addr[8] && t == i &&
               ((rd_en && addr[5:4] == 2'd0) || (wr_en && addr[5:4] == 2'd1)))
        m_irq[i] = 0;
    end
    for (int i = 0; i < 4; i++) m_cnt[i] = nc[i];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin m_rsync = 0; m_reset(); end
    else if (m_rsync < 2) begin m_rsync++; m_reset(); end
    else m_step();
  end

  // compare interrupts on every clock
  always @(negedge clk) begin
    bit [3:0] exp_n;
    for (int i = 0; i < 4; i++) exp_n[i] = ~m_irq[i];
    n_cmp++;
    if (irq_n !== exp_n) begin
      n_bad++;
      $display("FAIL %s irq_n act=%b exp=%b (t=%0t)", phase, irq_n, exp_n, $time);
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic wr(input bit [8:0] a, input bit [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input bit [8:0] a);
    bit [31:0] e;
    rd_en = 1; addr = a;
    #1;
    e = m_read(a);
    n_cmp++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s read @%h act=%h exp=%h", phase, a, rdata, e);
    end
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=<150000 cycles", cyc);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(5);
    // R1: reset state
    phase = "R1";
    rd(9'h100);
    for (int i = 0; i < 4; i++) begin
      rd(9'(i * 64));
      rd(9'(i * 64 + 16));
    end
    // R11 / R12: storage words at their offsets
    phase = "R11";
    for (int i = 0; i < 4; i++) begin
      wr(9'(i * 64 + 32), 32'hA5A5_0000 + 32'(i));
      wr(9'(i * 64 + 48), 32'h0F0F_1000 + 32'(i));
    end
    phase = "R12";
    for (int i = 0; i < 4; i++) begin
      rd(9'(i * 64 + 32));
      rd(9'(i * 64 + 48 + 4));
    end
    // R5: base write while inhibited loads the count
    phase = "R5";
    wr(9'h010, 32'h8000_0005);
    rd(9'h000);
    // R4: inhibited timer holds
    phase = "R4";
    idle(40);
    rd(9'h000);
    // R3: release and run, several intervals
    phase = "R3";
    wr(9'h010, 32'h0000_0005);
    idle(50);
    rd(9'h000);
    idle(45);
    rd(9'h000);
    // R6: level held, cleared by base write
    phase = "R6";
    idle(30);
    wr(9'h010, 32'h0000_0005);
    idle(3);
    rd(9'h000);
    // R7: count overwrite while running
    phase = "R7";
    wr(9'h000, 32'h0000_0002);
    rd(9'h000);
    idle(30);
    rd(9'h000);
    // R2: slower prescale
    phase = "R2";
    wr(9'h100, 32'h0000_0200);
    rd(9'h100);
    idle(300);
    rd(9'h000);
    wr(9'h100, 32'h0000_0300);
    idle(200);
    wr(9'h100, 32'h0000_0000);
    wr(9'h010, 32'h8000_0000);
    rd(9'h000);
    // R8: join timers 2 and 3, rollover on
    phase = "R8";
    wr(9'h100, 32'h0400_0004);
    wr(9'h0D0, 32'h8000_0000);
    wr(9'h090, 32'h0000_0014);
    rd(9'h080);
    wr(9'h0D0, 32'h0000_0000);
    wr(9'h0C0, 32'h0000_0001);
    wr(9'h080, 32'h0000_0002);
    idle(40);
    rd(9'h080);
    rd(9'h0C0);
    wr(9'h080, 32'h0000_000A);
    idle(100);
    rd(9'h0C0);
    idle(200);
    rd(9'h080);
    rd(9'h0C0);
    // R9: rollover clear rests at zero
    phase = "R9";
    wr(9'h100, 32'h0000_0004);
    wr(9'h080, 32'h0000_0005);
    idle(100);
    rd(9'h0C0);
    idle(60);
    rd(9'h080);
    rd(9'h0C0);
    // R10: overlapping joins, pair 0 wins
    phase = "R10";
    wr(9'h100, 32'h0300_0003);
    rd(9'h100);
    wr(9'h050, 32'h8000_0000);
    wr(9'h010, 32'h0000_0007);
    wr(9'h050, 32'h0000_0000);
    idle(120);
    rd(9'h000);
    rd(9'h040);
    rd(9'h080);
    idle(120);
    rd(9'h040);
    rd(9'h100);
    idle(4);
    finish_run();
  end
endmodule